// File: doc/BRIEF.md
# SCSI Bus Arbitration and Selection Sequencer

This block takes a SCSI device from an idle bus to a connected nexus. Once firmware sets the start bit, the sequencer waits for the bus to go quiet. It then arbitrates with its own ID bit. If it wins, it drives SEL together with the combined source and destination ID. In initiator mode this is a SELECTION phase. In target mode it is a RESELECTION phase, which the block marks by also driving I/O. Every step is a fixed count of clock cycles. With a 50 ns clock, the bus-free window is 8 cycles. The low-frequency mode halves every count.

A lost arbitration does not need firmware. The sequencer drops its drives, waits for the next quiet bus and tries again. When the other device answers with BSY, the block drops SEL and sets a sticky completion flag and interrupt. Firmware handles the selection timeout: it clears the start bit, and all drives are released on the next clock. A bus reset seen at any point also returns the block to idle.

Outputs are drive enables. The wired-OR bus is built outside the block, and the sampled bus lines come back in on `bsy_i`, `sel_i`, `rst_i` and `data_i`. ID priority rises with bit number, so bit 7 is the highest. `own_id_i` is a one-hot ID bit.

Top module: `scsi_arb_seq`

## Requirements
- R1: Arbitration starts only after BSY, SEL and RST have all been sampled low for 8 consecutive cycles. Counting from the first quiet cycle, `bsy_oe_o` rises 25 cycles later (8 quiet cycles + 1 + 16 cycles of delay).
- R2: While arbitrating, before SEL, the block drives `data_oe_o` high with `data_o` equal to `own_id_i`.
- R3: The decision is taken 56 cycles after `bsy_oe_o` rose. Arbitration is lost if `sel_i` is high or if any `data_i` bit above the own ID bit is set. Set bits below the own ID bit do not affect the outcome.
- R4: On a loss, `bsy_oe_o` and `data_oe_o` fall together. The block retries by itself, and `bsy_oe_o` rises again 25 cycles after the fall when the bus stays quiet.
- R5: On a win, `sel_oe_o` rises 80 cycles after `bsy_oe_o` rose, with `data_o` equal to own ID OR destination ID. `bsy_oe_o` then falls 2 cycles after `sel_oe_o` rose.
- R6: With `auto_atn_i` set, `atn_oe_o` rises in the same cycle as `sel_oe_o` and stays high until idle. With it clear, `atn_oe_o` stays low.
- R7: After SEL, when `bsy_i` is sampled high, `sel_oe_o` falls one cycle later. At that same point `cmd_done_o` and `irq_o` become 1.
- R8: In target mode (`target_i`=1), `io_oe_o` rises with `sel_oe_o`, and `bsy_oe_o` is driven again from completion onward. In initiator mode, `io_oe_o` stays low and `bsy_oe_o` is low after completion.
- R9: With `low_freq_i`=1 all counts are halved: 4 quiet cycles, 8 delay, 28 arbitration, 12 to SEL, 1 to BSY release. This gives 13 cycles from bus quiet to BSY and 40 cycles from BSY to SEL.
- R10: When `start_i` is low at a clock edge, all bus drives (`bsy_oe_o`, `sel_oe_o`, `atn_oe_o`, `io_oe_o`, `data_oe_o`) are low after that edge.
- R11: When `rst_i` is sampled high in any state, all bus drives are low after that edge. The sequence then restarts from bus-free detection.
- R12: `cmd_done_o` and `irq_o` stay set until a `clr_i` pulse is sampled. Clearing `start_i` does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (50 ns in high-frequency mode) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start arbitration/selection; low aborts |
| target_i | input | 1 | 1 = target role (reselection) |
| auto_atn_i | input | 1 | Raise ATN together with SEL |
| low_freq_i | input | 1 | Halve all cycle counts |
| own_id_i | input | 8 | One-hot own ID bit |
| dest_id_i | input | 8 | One-hot destination ID bit |
| bsy_i | input | 1 | Sampled bus BSY |
| sel_i | input | 1 | Sampled bus SEL |
| rst_i | input | 1 | Sampled bus RST |
| data_i | input | 8 | Sampled bus data lines |
| clr_i | input | 1 | Clear completion flag and interrupt |
| bsy_oe_o | output | 1 | Drive BSY |
| sel_oe_o | output | 1 | Drive SEL |
| atn_oe_o | output | 1 | Drive ATN |
| io_oe_o | output | 1 | Drive I/O |
| data_o | output | 8 | Data bus drive value |
| data_oe_o | output | 1 | Data bus drive enable |
| cmd_done_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | Sticky interrupt |

## Verification
The bench drives inputs and samples outputs on falling edges. It closes the bus loop itself by ORing the block's drives with modelled traffic from other devices. Each timed result is measured as a count of falling edges from the event that triggers it, and that count is compared with the figure in the requirement: 25 (or 13) cycles from bus quiet to BSY, 56 to a loss, 80 (or 40) from BSY to SEL, 2 (or 1) to BSY release. Reactions to a single sampled input are checked one falling edge after that input was applied. These are completion on BSY, abort on start-low and abort on RST, and each lands one register stage later.

// File: rtl/scsi_arb_pkg.sv
package scsi_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_FREE, ST_BUS_DLY, ST_ARB,
    ST_WIN_DLY, ST_SEL_BSY, ST_SEL_WAIT, ST_DONE
  } arb_state_e;

  function automatic int unsigned scale_cnt(input int unsigned n, input logic low);
    return low ? (n >> 1) : n;
  endfunction
endpackage

// File: rtl/scsi_arb_free_det.sv
module scsi_arb_free_det #(
  parameter int unsigned FREE_CYC = 8,
  parameter int unsigned CNT_W    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bsy_i,
  input  logic sel_i,
  input  logic rst_i,
  input  logic low_freq_i,
  output logic free_o
);
  import scsi_arb_pkg::*;
  logic [CNT_W-1:0] cnt_q, lim;

  assign lim = CNT_W'(scale_cnt(FREE_CYC, low_freq_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (bsy_i || sel_i || rst_i) cnt_q <= '0;
    else if (cnt_q < lim)            cnt_q <= cnt_q + CNT_W'(1);
  end

  assign free_o = (cnt_q >= lim);
endmodule

// File: rtl/scsi_arb_timer.sv
module scsi_arb_timer #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/scsi_arb_prio.sv
module scsi_arb_prio #(
  parameter int unsigned ID_W = 8
) (
  input  logic [ID_W-1:0] own_id_i,
  input  logic [ID_W-1:0] bus_id_i,
  output logic            higher_o
);
  logic [ID_W-1:0] above;

  assign above[0] = 1'b0;
  for (genvar i = 1; i < ID_W; i++) begin : g_mask
    assign above[i] = |own_id_i[i-1:0];
  end

  assign higher_o = |(bus_id_i & above);
endmodule

// File: rtl/scsi_arb_seq.sv
module scsi_arb_seq #(
  parameter int unsigned ID_W     = 8,
  parameter int unsigned FREE_CYC = 8,
  parameter int unsigned T_BUS    = 16,
  parameter int unsigned T_ARB    = 56,
  parameter int unsigned T_SEL    = 24,
  parameter int unsigned T_REL    = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            target_i,
  input  logic            auto_atn_i,
  input  logic            low_freq_i,
  input  logic [ID_W-1:0] own_id_i,
  input  logic [ID_W-1:0] dest_id_i,
  input  logic            bsy_i,
  input  logic            sel_i,
  input  logic            rst_i,
  input  logic [ID_W-1:0] data_i,
  input  logic            clr_i,
  output logic            bsy_oe_o,
  output logic            sel_oe_o,
  output logic            atn_oe_o,
  output logic            io_oe_o,
  output logic [ID_W-1:0] data_o,
  output logic            data_oe_o,
  output logic            cmd_done_o,
  output logic            irq_o
);
  import scsi_arb_pkg::*;

  localparam int unsigned MAX_A = (T_BUS > T_ARB) ? T_BUS : T_ARB;
  localparam int unsigned MAX_B = (T_SEL > T_REL) ? T_SEL : T_REL;
  localparam int unsigned MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);
  localparam int unsigned FRE_W = $clog2(FREE_CYC + 1);

  arb_state_e       st_q, st_d;
  logic             bus_free, tmr_zero, tmr_ld, higher, done_q;
  logic [CNT_W-1:0] tmr_val;

  scsi_arb_free_det #(.FREE_CYC(FREE_CYC), .CNT_W(FRE_W)) u_free (
    .clk_i(clk_i), .rst_ni(rst_ni), .bsy_i(bsy_i), .sel_i(sel_i),
    .rst_i(rst_i), .low_freq_i(low_freq_i), .free_o(bus_free)
  );

  scsi_arb_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_ld),
    .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  scsi_arb_prio #(.ID_W(ID_W)) u_prio (
    .own_id_i(own_id_i), .bus_id_i(data_i), .higher_o(higher)
  );

  // timer loaded with count-1 so a timed state lasts exactly count cycles
  always_comb begin
    st_d    = st_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    unique case (st_q)
      ST_IDLE:      if (start_i) st_d = ST_WAIT_FREE;
      ST_WAIT_FREE: if (bus_free) begin
        st_d = ST_BUS_DLY; tmr_ld = 1'b1;
        tmr_val = CNT_W'(scale_cnt(T_BUS, low_freq_i) - 1);
      end
      ST_BUS_DLY:   if (tmr_zero) begin
        st_d = ST_ARB; tmr_ld = 1'b1;
        tmr_val = CNT_W'(scale_cnt(T_ARB, low_freq_i) - 1);
      end
      ST_ARB:       if (tmr_zero) begin
        if (sel_i || higher) st_d = ST_WAIT_FREE;
        else begin
          st_d = ST_WIN_DLY; tmr_ld = 1'b1;
          tmr_val = CNT_W'(scale_cnt(T_SEL, low_freq_i) - 1);
        end
      end
      ST_WIN_DLY:   if (tmr_zero) begin
        st_d = ST_SEL_BSY; tmr_ld = 1'b1;
        tmr_val = CNT_W'(scale_cnt(T_REL, low_freq_i) - 1);
      end
      ST_SEL_BSY:   if (tmr_zero) st_d = ST_SEL_WAIT;
      ST_SEL_WAIT:  if (bsy_i) st_d = ST_DONE;
      ST_DONE:      st_d = ST_DONE;
      default:      st_d = ST_IDLE;
    endcase
    if (!start_i || rst_i) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_SEL_WAIT && st_d == ST_DONE) done_q <= 1'b1;
      else if (clr_i)                             done_q <= 1'b0;
    end
  end

  logic in_sel, in_arb;
  assign in_arb = (st_q == ST_ARB) || (st_q == ST_WIN_DLY);
  assign in_sel = (st_q == ST_SEL_BSY) || (st_q == ST_SEL_WAIT);

  assign bsy_oe_o   = in_arb || (st_q == ST_SEL_BSY) || (target_i && st_q == ST_DONE);
  assign sel_oe_o   = in_sel;
  assign atn_oe_o   = auto_atn_i && (in_sel || st_q == ST_DONE);
  assign io_oe_o    = target_i && (in_sel || st_q == ST_DONE);
  assign data_oe_o  = in_arb || in_sel;
  assign data_o     = in_arb ? own_id_i : (in_sel ? (own_id_i | dest_id_i) : '0);
  assign cmd_done_o = done_q;
  assign irq_o      = done_q;
endmodule

// File: rtl/scsi_arb_seq_chk.sv
module scsi_arb_seq_chk #(
  parameter int unsigned ID_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            rst_i,
  input logic            auto_atn_i,
  input logic            clr_i,
  input logic [ID_W-1:0] own_id_i,
  input logic            bsy_oe_o,
  input logic            sel_oe_o,
  input logic            atn_oe_o,
  input logic            data_oe_o,
  input logic [ID_W-1:0] data_o,
  input logic            cmd_done_o
);
  p_arb_own_id_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsy_oe_o && !sel_oe_o && data_oe_o |-> data_o == own_id_i);

  p_sel_under_bsy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_oe_o) |-> $past(bsy_oe_o) && bsy_oe_o);

  p_bsy_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bsy_oe_o) && sel_oe_o |-> $past(sel_oe_o));

  p_atn_with_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(atn_oe_o) |-> sel_oe_o && auto_atn_i);

  p_done_drops_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_done_o) |-> !sel_oe_o && $past(sel_oe_o));

  p_stop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !bsy_oe_o && !sel_oe_o && !data_oe_o);

  p_rst_abort_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_i |=> !bsy_oe_o && !sel_oe_o && !data_oe_o);

  p_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_o && !clr_i |=> cmd_done_o);
endmodule

bind scsi_arb_seq scsi_arb_seq_chk #(.ID_W(ID_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rst_i(rst_i),
  .auto_atn_i(auto_atn_i), .clr_i(clr_i), .own_id_i(own_id_i),
  .bsy_oe_o(bsy_oe_o), .sel_oe_o(sel_oe_o), .atn_oe_o(atn_oe_o),
  .data_oe_o(data_oe_o), .data_o(data_o), .cmd_done_o(cmd_done_o)
);

// File: tb/scsi_arb_seq_tb.sv
`timescale 1ns/1ps
module scsi_arb_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, target = 0, auto_atn = 0, low_freq = 0, clr = 0;
  logic [7:0] own_id = 8'h10, dest_id = 8'h02;
  logic o_bsy = 0, o_sel = 0, o_rst = 0;
  logic [7:0] o_data = 8'h00;
  logic bsy_oe, sel_oe, atn_oe, io_oe, data_oe, cmd_done, irq;
  logic [7:0] data_drv;
  logic bsy_bus, sel_bus;
  logic [7:0] data_bus;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  assign bsy_bus  = bsy_oe | o_bsy;
  assign sel_bus  = sel_oe | o_sel;
  assign data_bus = (data_oe ? data_drv : 8'h00) | o_data;

  scsi_arb_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .target_i(target),
    .auto_atn_i(auto_atn), .low_freq_i(low_freq), .own_id_i(own_id),
    .dest_id_i(dest_id), .bsy_i(bsy_bus), .sel_i(sel_bus), .rst_i(o_rst),
    .data_i(data_bus), .clr_i(clr), .bsy_oe_o(bsy_oe), .sel_oe_o(sel_oe),
    .atn_oe_o(atn_oe), .io_oe_o(io_oe), .data_o(data_drv),
    .data_oe_o(data_oe), .cmd_done_o(cmd_done), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // which: 0 bsy_oe, 1 sel_oe
  task automatic wait_sig(input int which, input logic lvl, output int n);
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      n++;
      if ((which == 0 ? bsy_oe : sel_oe) == lvl) return;
    end
    n = -1;
  endtask

  // bus busy, start set, then bus released; returns cycles until BSY drive
  task automatic arm(output int n);
    o_bsy = 1; start = 1;
    repeat (3) @(negedge clk);
    o_bsy = 0;
    wait_sig(0, 1'b1, n);
  endtask

  task automatic idle_out();
    start = 0; o_bsy = 0; o_sel = 0; o_rst = 0; o_data = 0;
    clr = 1; @(negedge clk); clr = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 reset bsy", bsy_oe, 0);
    chk("R10 reset sel/data", int'(sel_oe | data_oe | atn_oe | io_oe), 0);
    chk("R12 reset done/irq", int'(cmd_done | irq), 0);
  endtask

  task automatic t_init_win();
    int n;
    target = 0; auto_atn = 1; low_freq = 0; own_id = 8'h10; dest_id = 8'h02;
    arm(n);
    chk("R1 quiet to BSY", n, 25);
    chk("R2 arb data_oe", data_oe, 1);
    chk("R2 arb data", data_drv, 8'h10);
    chk("R6 no ATN in arb", atn_oe, 0);
    wait_sig(1, 1'b1, n);
    chk("R5 BSY to SEL", n, 80);
    chk("R5 sel data", data_drv, 8'h12);
    chk("R6 ATN with SEL", atn_oe, 1);
    chk("R8 init no IO", io_oe, 0);
    wait_sig(0, 1'b0, n);
    chk("R5 BSY release", n, 2);
    repeat (5) @(negedge clk);
    chk("R7 done not early", cmd_done, 0);
    o_bsy = 1;
    @(negedge clk);
    chk("R7 SEL dropped", sel_oe, 0);
    chk("R7 done", cmd_done, 1);
    chk("R7 irq", irq, 1);
    chk("R8 init BSY off", bsy_oe, 0);
    chk("R6 ATN held", atn_oe, 1);
    start = 0;
    repeat (5) @(negedge clk);
    chk("R12 sticky done", int'(cmd_done & irq), 1);
    chk("R10 ATN off idle", atn_oe, 0);
    clr = 1; @(negedge clk); clr = 0;
    chk("R12 cleared", int'(cmd_done | irq), 0);
    idle_out();
  endtask

  task automatic t_lose_hi();
    int n;
    auto_atn = 0; own_id = 8'h10;
    o_data = 8'h80;
    arm(n);
    wait_sig(0, 1'b0, n);
    chk("R3 lose to higher ID", n, 56);
    chk("R4 data released", data_oe, 0);
    chk("R3 no SEL on loss", sel_oe, 0);
    wait_sig(0, 1'b1, n);
    chk("R4 retry BSY", n, 25);
    idle_out();
  endtask

  task automatic t_lose_sel();
    int n;
    arm(n);
    repeat (5) @(negedge clk);
    o_sel = 1;
    wait_sig(0, 1'b0, n);
    chk("R3 lose to SEL", n, 51);
    idle_out();
  endtask

  task automatic t_lower_id();
    int n;
    o_data = 8'h01;
    arm(n);
    wait_sig(1, 1'b1, n);
    chk("R3 lower ID ignored", n, 80);
    idle_out();
  endtask

  task automatic t_target_low();
    int n;
    target = 1; low_freq = 1; auto_atn = 0;
    arm(n);
    chk("R9 quiet to BSY low", n, 13);
    wait_sig(1, 1'b1, n);
    chk("R9 BSY to SEL low", n, 40);
    chk("R8 IO with SEL", io_oe, 1);
    chk("R6 no ATN", atn_oe, 0);
    wait_sig(0, 1'b0, n);
    chk("R9 release low", n, 1);
    o_bsy = 1;
    @(negedge clk);
    chk("R8 target BSY reasserted", bsy_oe, 1);
    chk("R7 target SEL off", sel_oe, 0);
    chk("R7 target done", cmd_done, 1);
    idle_out();
    target = 0; low_freq = 0;
  endtask

  task automatic t_start_drop();
    int n;
    auto_atn = 1;
    arm(n);
    wait_sig(1, 1'b1, n);
    repeat (4) @(negedge clk);
    start = 0;
    @(negedge clk);
    chk("R10 drives off", int'(bsy_oe | sel_oe | atn_oe | data_oe | io_oe), 0);
    chk("R10 no done", cmd_done, 0);
    idle_out();
  endtask

  task automatic t_rst_abort();
    int n;
    arm(n);
    repeat (10) @(negedge clk);
    o_rst = 1;
    @(negedge clk);
    chk("R11 rst abort", int'(bsy_oe | data_oe), 0);
    @(negedge clk);
    o_rst = 0;
    wait_sig(0, 1'b1, n);
    chk("R11 restart after rst", n, 25);
    idle_out();
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_init_win();
    t_lose_hi();
    t_lose_sel();
    t_lower_id();
    t_target_low();
    t_start_drop();
    t_rst_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule